// File: doc/BRIEF.md
# DMA Channel Sequencer with Descriptor Chaining

This block sequences one DMA channel. Software programs it through a small word-addressed register file. The registers are a control word, a status word, and the source, destination, byte-count and descriptor-pointer registers. A clear-then-set of the start bit launches a run. The block does not move data itself. It hands each segment (source, destination, length) to an external transfer engine with a one-cycle start pulse, then waits for that engine to report done or error.

The control word has a mode bit that selects one of two ways of working. In direct mode the block runs one segment from the values software has written into the registers. In chaining mode it reads a four-word descriptor from memory through a simple request/acknowledge read port. The read starts at the descriptor pointer. The descriptor words are loaded straight into the working registers, and that segment is run. The block then follows the descriptor's link word until it reaches a descriptor flagged as the end of the chain. An engine error stops the run at once and sets a sticky error flag. A clean finish sets a sticky completion flag. Both flags are cleared by writing 1 to them.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, `busy`, `xfer_start` and `mem_req` are 0, and the status word (offset 1) reads 0.
- R2: A run launches only when a write to the control word (offset 0) sets its start bit (bit 1) while the stored start bit is 0. A write of 1 over a stored 1 launches nothing.
- R3: `busy` is 1 from the cycle after the launching write until the run ends. It also reads back as status bit 0. A start edge that arrives while busy is ignored.
- R4: In direct mode (control bit 0 = 0), exactly one `xfer_start` pulse is issued. It carries the source (offset 2), destination (offset 3) and byte-count (offset 4) registers.
- R5: When `xfer_done` arrives and no further segment follows, `busy` drops on the next cycle and the sticky done flag (status bit 1) is set.
- R6: `xfer_err` during a segment sets the sticky error flag (status bit 2) and drops `busy` on the next cycle. No further descriptor is fetched.
- R7: In chaining mode (control bit 0 = 1), a descriptor is read as four words at pointer+0, +4, +8 and +12, in that order: source, destination, link, byte count. The first descriptor is read at the descriptor-pointer register (offset 5). `mem_addr` holds steady while `mem_req` waits for `mem_ack`.
- R8: The link word, with bit 0 cleared, is written into the descriptor-pointer register. After the segment, the next descriptor is fetched from that address.
- R9: A descriptor whose link word has bit 0 set ends the chain when its segment completes, and the done flag is set.
- R10: Writing 1 to status bit 1 or bit 2 clears that flag. Status bit 0 cannot be written.
- R11: A segment with a byte count of 0 issues no `xfer_start` and counts as completed at once, in both modes.
- R12: Writes to offsets 2 to 5 are ignored while `busy` is 1.

Ports follow in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write word offset |
| reg_wdata | input | DW | Register write data |
| reg_raddr | input | 3 | Register read word offset |
| reg_rdata | output | DW | Register read data (combinational) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | DW | Descriptor word byte address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | DW | Descriptor word read data |
| xfer_start | output | 1 | One-cycle segment launch pulse |
| xfer_src | output | DW | Segment source address |
| xfer_dst | output | DW | Segment destination address |
| xfer_len | output | DW | Segment byte count |
| xfer_done | input | 1 | Engine finished the segment |
| xfer_err | input | 1 | Engine reports an error |
| busy | output | 1 | Channel active |

## Verification
A corrupted sequencer state shows up at the ports within one or two cycles. It appears as an `xfer_start` pulse that no expected segment matches, or as a descriptor read at an address the chain did not call for. It can also appear as `busy` failing to drop in the cycle after done or error. A wrong link pointer or a wrong end-of-chain flag is caught at the next fetch address, or when a whole descriptor is fetched that should not have been. Stale working registers appear as mismatched source, destination or length on the very next launch. The sticky flags are read back after every run.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  // register word offsets
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] OFS_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] OFS_STAT = 3'd1;
  localparam logic [REG_AW-1:0] OFS_SRC  = 3'd2;
  localparam logic [REG_AW-1:0] OFS_DST  = 3'd3;
  localparam logic [REG_AW-1:0] OFS_CNT  = 3'd4;
  localparam logic [REG_AW-1:0] OFS_DESC = 3'd5;

  // control and status bit positions
  localparam int CTRL_MODE  = 0;
  localparam int CTRL_START = 1;
  localparam int ST_BUSY    = 0;
  localparam int ST_DONE    = 1;
  localparam int ST_ERR     = 2;

  // descriptor layout
  localparam int DESC_WORDS = 4;
  localparam int DESC_IDX_W = $clog2(DESC_WORDS);
  localparam logic [DESC_IDX_W-1:0] DW_SRC  = 2'd0;
  localparam logic [DESC_IDX_W-1:0] DW_DST  = 2'd1;
  localparam logic [DESC_IDX_W-1:0] DW_LINK = 2'd2;
  localparam logic [DESC_IDX_W-1:0] DW_CNT  = 2'd3;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_FETCH  = 2'd1,
    SEQ_LAUNCH = 2'd2,
    SEQ_WAIT   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
  import dma_seq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_AW-1:0]     wr_addr,
  input  logic [DW-1:0]         wr_data,
  input  logic [REG_AW-1:0]     rd_addr,
  output logic [DW-1:0]         rd_data,
  input  logic                  busy,
  input  logic                  set_done,
  input  logic                  set_err,
  input  logic                  ld_en,
  input  logic [DESC_IDX_W-1:0] ld_idx,
  input  logic [DW-1:0]         ld_data,
  output logic                  chain_mode,
  output logic                  start_edge,
  output logic [DW-1:0]         src_q,
  output logic [DW-1:0]         dst_q,
  output logic [DW-1:0]         cnt_q,
  output logic [DW-1:0]         desc_q,
  output logic                  last_q
);
  logic          mode_q, start_q, done_q, err_q;
  logic          mode_d, start_d, done_d, err_d, last_d;
  logic [DW-1:0] src_d, dst_d, cnt_d, desc_d;
  logic          wr_ctrl, wr_stat, wr_work;

  assign wr_ctrl = wr_en && (wr_addr == OFS_CTRL);
  assign wr_stat = wr_en && (wr_addr == OFS_STAT);
  assign wr_work = wr_en && !busy;

  // start edge: the stored start bit goes from 0 to 1
  assign start_edge = wr_ctrl && wr_data[CTRL_START] && !start_q;
  assign chain_mode = mode_d;

  always_comb begin
    mode_d  = mode_q;
    start_d = start_q;
    done_d  = done_q;
    err_d   = err_q;
    src_d   = src_q;
    dst_d   = dst_q;
    cnt_d   = cnt_q;
    desc_d  = desc_q;
    last_d  = last_q;
    if (wr_ctrl) begin
      mode_d  = wr_data[CTRL_MODE];
      start_d = wr_data[CTRL_START];
    end
    if (wr_stat) begin
      if (wr_data[ST_DONE]) done_d = 1'b0;
      if (wr_data[ST_ERR])  err_d  = 1'b0;
    end
    if (set_done) done_d = 1'b1;
    if (set_err)  err_d  = 1'b1;
    if (wr_work) begin
      case (wr_addr)
        OFS_SRC:  src_d  = wr_data;
        OFS_DST:  dst_d  = wr_data;
        OFS_CNT:  cnt_d  = wr_data;
        OFS_DESC: desc_d = wr_data;
        default: ;
      endcase
    end
    if (ld_en) begin
      case (ld_idx)
        DW_SRC:  src_d = ld_data;
        DW_DST:  dst_d = ld_data;
        DW_LINK: begin
          desc_d = {ld_data[DW-1:1], 1'b0};
          last_d = ld_data[0];
        end
        default: cnt_d = ld_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      desc_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      start_q <= start_d;
      done_q  <= done_d;
      err_q   <= err_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      cnt_q   <= cnt_d;
      desc_q  <= desc_d;
      last_q  <= last_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_CTRL: begin
        rd_data[CTRL_MODE]  = mode_q;
        rd_data[CTRL_START] = start_q;
      end
      OFS_STAT: begin
        rd_data[ST_BUSY] = busy;
        rd_data[ST_DONE] = done_q;
        rd_data[ST_ERR]  = err_q;
      end
      OFS_SRC:  rd_data = src_q;
      OFS_DST:  rd_data = dst_q;
      OFS_CNT:  rd_data = cnt_q;
      OFS_DESC: rd_data = desc_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dma_seq_fetch.sv
module dma_seq_fetch
  import dma_seq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [DW-1:0]         base_in,
  output logic                  mem_req,
  output logic [DW-1:0]         mem_addr,
  input  logic                  mem_ack,
  input  logic [DW-1:0]         mem_rdata,
  output logic                  ld_en,
  output logic [DESC_IDX_W-1:0] ld_idx,
  output logic [DW-1:0]         ld_data,
  output logic                  fetch_done
);
  localparam int STRIDE_LG = $clog2(DW / 8);
  localparam logic [DESC_IDX_W-1:0] IDX_LAST = DESC_IDX_W'(DESC_WORDS - 1);

  logic                  active_q, active_d;
  logic [DESC_IDX_W-1:0] idx_q, idx_d;
  logic [DW-1:0]         base_q, base_d;
  logic [DW-1:0]         offset;

  always_comb begin
    offset = '0;
    offset[STRIDE_LG +: DESC_IDX_W] = idx_q;
  end

  assign mem_req    = active_q;
  assign mem_addr   = base_q + offset;
  assign ld_en      = active_q && mem_ack;
  assign ld_idx     = idx_q;
  assign ld_data    = mem_rdata;
  assign fetch_done = ld_en && (idx_q == IDX_LAST);

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    base_d   = base_q;
    if (go) begin
      active_d = 1'b1;
      idx_d    = '0;
      base_d   = base_in;
    end else if (ld_en) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == IDX_LAST) active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      if (go) base_q <= base_d;
    end
  end
endmodule

// File: rtl/dma_seq_ctl.sv
module dma_seq_ctl
  import dma_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_edge,
  input  logic chain_mode,
  input  logic cnt_zero,
  input  logic last_desc,
  input  logic fetch_done,
  input  logic xfer_done,
  input  logic xfer_err,
  output logic busy,
  output logic fetch_go,
  output logic xfer_start,
  output logic set_done,
  output logic set_err
);
  seq_state_t st_q, st_d;
  logic       chain_q;
  logic       take_start;
  logic       seg_end;

  assign busy       = (st_q != SEQ_IDLE);
  assign take_start = (st_q == SEQ_IDLE) && start_edge;

  always_comb begin
    st_d       = st_q;
    fetch_go   = 1'b0;
    xfer_start = 1'b0;
    set_done   = 1'b0;
    set_err    = 1'b0;
    seg_end    = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (start_edge) begin
          if (chain_mode) begin
            st_d     = SEQ_FETCH;
            fetch_go = 1'b1;
          end else begin
            st_d = SEQ_LAUNCH;
          end
        end
      end
      SEQ_FETCH: begin
        if (fetch_done) st_d = SEQ_LAUNCH;
      end
      SEQ_LAUNCH: begin
        if (cnt_zero) begin
          seg_end = 1'b1;
        end else begin
          xfer_start = 1'b1;
          st_d       = SEQ_WAIT;
        end
      end
      SEQ_WAIT: begin
        if (xfer_err) begin
          set_err = 1'b1;
          st_d    = SEQ_IDLE;
        end else if (xfer_done) begin
          seg_end = 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
    if (seg_end) begin
      if (!chain_q || last_desc) begin
        set_done = 1'b1;
        st_d     = SEQ_IDLE;
      end else begin
        fetch_go = 1'b1;
        st_d     = SEQ_FETCH;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      chain_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (take_start) chain_q <= chain_mode;
    end
  end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_seq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [DW-1:0]     reg_rdata,
  output logic              mem_req,
  output logic [DW-1:0]     mem_addr,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              xfer_start,
  output logic [DW-1:0]     xfer_src,
  output logic [DW-1:0]     xfer_dst,
  output logic [DW-1:0]     xfer_len,
  input  logic              xfer_done,
  input  logic              xfer_err,
  output logic              busy
);
  logic [1:0]            rst_pipe;
  logic                  rst_core_n;
  logic                  set_done, set_err, fetch_go, fetch_done;
  logic                  ld_en, chain_mode, start_edge, last_q;
  logic [DESC_IDX_W-1:0] ld_idx;
  logic [DW-1:0]         ld_data, cnt_q, desc_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign xfer_len = cnt_q;

  dma_seq_regs #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_en      (reg_wr),
    .wr_addr    (reg_waddr),
    .wr_data    (reg_wdata),
    .rd_addr    (reg_raddr),
    .rd_data    (reg_rdata),
    .busy       (busy),
    .set_done   (set_done),
    .set_err    (set_err),
    .ld_en      (ld_en),
    .ld_idx     (ld_idx),
    .ld_data    (ld_data),
    .chain_mode (chain_mode),
    .start_edge (start_edge),
    .src_q      (xfer_src),
    .dst_q      (xfer_dst),
    .cnt_q      (cnt_q),
    .desc_q     (desc_q),
    .last_q     (last_q)
  );

  dma_seq_fetch #(.DW(DW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .go         (fetch_go),
    .base_in    (desc_q),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .ld_en      (ld_en),
    .ld_idx     (ld_idx),
    .ld_data    (ld_data),
    .fetch_done (fetch_done)
  );

  dma_seq_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start_edge (start_edge),
    .chain_mode (chain_mode),
    .cnt_zero   (cnt_q == '0),
    .last_desc  (last_q),
    .fetch_done (fetch_done),
    .xfer_done  (xfer_done),
    .xfer_err   (xfer_err),
    .busy       (busy),
    .fetch_go   (fetch_go),
    .xfer_start (xfer_start),
    .set_done   (set_done),
    .set_err    (set_err)
  );
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk
  import dma_seq_pkg::*;
#(
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_waddr,
  input logic [DW-1:0]     reg_wdata,
  input logic              mem_req,
  input logic [DW-1:0]     mem_addr,
  input logic              mem_ack,
  input logic              xfer_start,
  input logic              xfer_err,
  input logic              busy
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!xfer_start && !mem_req));

  p_launch_needs_start_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && (reg_waddr == OFS_CTRL) && reg_wdata[CTRL_START]));

  p_launch_while_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> busy);

  p_single_launch_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  p_error_ends_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_err) |=> (!busy && !mem_req));

  p_fetch_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_fetch_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
endmodule

bind dma_chain_seq dma_chain_seq_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_waddr  (reg_waddr),
  .reg_wdata  (reg_wdata),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack),
  .xfer_start (xfer_start),
  .xfer_err   (xfer_err),
  .busy       (busy)
);

// File: tb/dma_chain_seq_bench.sv
module dma_chain_seq_bench;
  import dma_seq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [REG_AW-1:0] reg_waddr = '0;
  logic [DW-1:0]     reg_wdata = '0;
  logic [REG_AW-1:0] reg_raddr = '0;
  logic [DW-1:0]     reg_rdata;
  logic              mem_req;
  logic [DW-1:0]     mem_addr;
  logic              mem_ack = 1'b0;
  logic [DW-1:0]     mem_rdata = '0;
  logic              xfer_start;
  logic [DW-1:0]     xfer_src, xfer_dst, xfer_len;
  logic              xfer_done = 1'b0;
  logic              xfer_err = 1'b0;
  logic              busy;

  dma_chain_seq #(.DW(DW)) u_dma_chain_seq (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [DW-1:0] src;
    logic [DW-1:0] dst;
    logic [DW-1:0] len;
  } seg_t;

  seg_t          seg_q[$];
  logic [DW-1:0] fetch_q[$];
  logic [DW-1:0] mem[64];
  int n_vec = 0;
  int n_bad = 0;
  int starts = 0;
  int err_at = -1;
  int eng_cnt = 0;
  int eng_delay = 10;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [REG_AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [REG_AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_raddr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push_seg(input logic [DW-1:0] s, input logic [DW-1:0] d,
                          input logic [DW-1:0] l);
    seg_t e;
    e.src = s; e.dst = d; e.len = l;
    seg_q.push_back(e);
  endtask

  task automatic push_desc(input logic [DW-1:0] a);
    for (int i = 0; i < 4; i++) fetch_q.push_back(a + DW'(4 * i));
  endtask

  task automatic wait_idle(input string tag);
    int n;
    n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
    if (busy) chk(1'b0, {tag, " run never ended"}, 32'(busy), 32'd0);
  endtask

  // engine and memory models plus monitor, all at the falling edge
  always @(negedge clk) begin
    if (xfer_done || xfer_err) begin
      xfer_done = 1'b0;
      xfer_err  = 1'b0;
    end
    if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        if (starts == err_at) xfer_err = 1'b1;
        else                  xfer_done = 1'b1;
      end
    end
    if (xfer_start) begin
      starts++;
      eng_cnt = eng_delay;
      if (seg_q.size() == 0) begin
        chk(1'b0, "R4 unexpected segment launch", xfer_src, '0);
      end else begin
        seg_t e;
        e = seg_q.pop_front();
        chk(xfer_src == e.src, "R4 segment source", xfer_src, e.src);
        chk(xfer_dst == e.dst, "R4 segment destination", xfer_dst, e.dst);
        chk(xfer_len == e.len, "R4 segment length", xfer_len, e.len);
      end
    end
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (fetch_q.size() == 0) begin
        chk(1'b0, "R7 unexpected descriptor read", mem_addr, '0);
      end else begin
        logic [DW-1:0] ea;
        ea = fetch_q.pop_front();
        chk(mem_addr == ea, "R7 descriptor read address", mem_addr, ea);
      end
      mem_rdata = mem[mem_addr[7:2]];
      mem_ack   = 1'b1;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    int s0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    // chain A: 0x40 -> 0x80 (zero length) -> 0xC0 (last)
    mem[6'h10] = 32'h100; mem[6'h11] = 32'h200; mem[6'h12] = 32'h80;  mem[6'h13] = 32'h10;
    mem[6'h20] = 32'h300; mem[6'h21] = 32'h400; mem[6'h22] = 32'hC0;  mem[6'h23] = 32'h0;
    mem[6'h30] = 32'h500; mem[6'h31] = 32'h600; mem[6'h32] = 32'h1F1; mem[6'h33] = 32'h20;
    // chain B: 0x20 -> 0x40, engine fails on first segment
    mem[6'h08] = 32'h700; mem[6'h09] = 32'h800; mem[6'h0A] = 32'h40;  mem[6'h0B] = 32'h8;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!busy, "R1 busy after reset", 32'(busy), 32'd0);
    chk(!xfer_start && !mem_req, "R1 outputs quiet after reset",
        {30'd0, xfer_start, mem_req}, 32'd0);
    rd(OFS_STAT, v);
    chk(v == 32'd0, "R1 status after reset", v, 32'd0);

    // direct mode run
    wr(OFS_SRC, 32'h1000);
    wr(OFS_DST, 32'h2000);
    wr(OFS_CNT, 32'h40);
    wr(OFS_CTRL, 32'h0);
    push_seg(32'h1000, 32'h2000, 32'h40);
    wr(OFS_CTRL, 32'h2);
    chk(busy, "R3 busy after start", 32'(busy), 32'd1);
    wr(OFS_SRC, 32'h5555);                 // R12 ignored while busy
    wr(OFS_CTRL, 32'h0);
    wr(OFS_CTRL, 32'h2);                   // R3 edge while busy ignored
    wait_idle("R5");
    rd(OFS_STAT, v);
    chk(v == 32'h2, "R5 done flag, busy clear", v, 32'h2);
    rd(OFS_SRC, v);
    chk(v == 32'h1000, "R12 source kept while busy", v, 32'h1000);
    repeat (15) @(negedge clk);
    chk(starts == 1, "R3 start while busy launched nothing", 32'(starts), 32'd1);

    // R2 no edge: start bit already 1
    wr(OFS_CTRL, 32'h2);
    repeat (3) @(negedge clk);
    chk(!busy && starts == 1, "R2 repeated start without clear",
        32'(starts), 32'd1);

    // R10 status clear and read-only busy bit
    wr(OFS_STAT, 32'h2);
    rd(OFS_STAT, v);
    chk(v == 32'h0, "R10 done flag cleared by 1", v, 32'h0);
    wr(OFS_STAT, 32'h1);
    rd(OFS_STAT, v);
    chk(v == 32'h0, "R10 busy bit not writable", v, 32'h0);

    // R11 direct zero-length
    s0 = starts;
    wr(OFS_CNT, 32'h0);
    wr(OFS_CTRL, 32'h0);
    wr(OFS_CTRL, 32'h2);
    wait_idle("R11");
    rd(OFS_STAT, v);
    chk(v == 32'h2, "R11 zero length completes", v, 32'h2);
    chk(starts == s0, "R11 zero length no launch", 32'(starts), 32'(s0));
    wr(OFS_STAT, 32'h6);

    // chaining mode, three descriptors, middle one zero length
    s0 = starts;
    push_desc(32'h40);
    push_desc(32'h80);
    push_desc(32'hC0);
    push_seg(32'h100, 32'h200, 32'h10);
    push_seg(32'h500, 32'h600, 32'h20);
    wr(OFS_DESC, 32'h40);
    wr(OFS_CTRL, 32'h1);
    wr(OFS_CTRL, 32'h3);
    wait_idle("R9");
    rd(OFS_STAT, v);
    chk(v == 32'h2, "R9 chain ends with done", v, 32'h2);
    chk(fetch_q.size() == 0, "R7 all descriptors fetched", 32'(fetch_q.size()), 32'd0);
    chk(seg_q.size() == 0, "R8 all segments launched", 32'(seg_q.size()), 32'd0);
    chk(starts == s0 + 2, "R11 zero-length segment skipped", 32'(starts), 32'(s0 + 2));
    rd(OFS_DESC, v);
    chk(v == 32'h1F0, "R8 pointer from link word", v, 32'h1F0);
    rd(OFS_SRC, v);
    chk(v == 32'h500, "R9 last descriptor loaded", v, 32'h500);
    wr(OFS_STAT, 32'h2);

    // R6 error terminates chain
    err_at = starts + 1;
    push_desc(32'h20);
    push_seg(32'h700, 32'h800, 32'h8);
    wr(OFS_DESC, 32'h20);
    wr(OFS_CTRL, 32'h1);
    wr(OFS_CTRL, 32'h3);
    wait_idle("R6");
    repeat (5) @(negedge clk);
    err_at = -1;
    rd(OFS_STAT, v);
    chk(v == 32'h4, "R6 error flag, busy clear", v, 32'h4);
    chk(fetch_q.size() == 0 && !busy, "R6 no fetch after error",
        32'(fetch_q.size()), 32'd0);
    rd(OFS_DESC, v);
    chk(v == 32'h40, "R6 remaining chain abandoned", v, 32'h40);
    wr(OFS_STAT, 32'h4);
    rd(OFS_STAT, v);
    chk(v == 32'h0, "R10 error flag cleared by 1", v, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule